// File: doc/BRIEF.md
# Interrupt Distributor Register Bank

This block holds the per-interrupt configuration and state for a small interrupt controller with up to `NUM_IRQ` interrupt lines (64 by default). Each interrupt carries a group bit, an enable bit, a pending bit, an active bit, an 8-bit priority and a trigger mode. Software reaches all of it over a plain 32-bit register bus. Enable, pending and active each have a separate set register and clear register, so no read-modify-write is ever needed. The bank exports its state vectors and a gated request vector to a downstream arbitration block.

IDs 0 to 15 are software-generated: only software can make them pending, and they are always edge type. IDs 16 to 31 are private peripheral lines and IDs from 32 upward are shared peripheral lines. State for IDs below 32 lives only in a private window at byte address 0x800. State for shared IDs lives only in the shared window at byte address 0x000. Level inputs keep their pending bit set for as long as they are high. Edge inputs set it on a rising transition.

Top module: `idg_dist_regs`

## Requirements
- R1: IDs 0..15 ignore `irq_i` entirely; their trigger field always reads 2'b10 (edge) and writes to it are dropped; IDs 16 and above take their pending input from `irq_i`.
- R2: Enable, pending and active each have a set register (window offsets 0x100, 0x200, 0x300) and a clear register (0x180, 0x280, 0x380); a 1 written to a bit sets or clears that interrupt's state the next cycle, a 0 bit changes nothing, and reading either register of a pair returns the current state word.
- R3: In every one-bit-per-interrupt register (group at 0x080 and the six set/clear registers), interrupt ID sits in word ID/32 at bit ID mod 32.
- R4: Priority is one byte per interrupt at byte offset 0x400 + ID within its window, little-endian within the word; it resets to 0 and appears on `prio_o[8*ID +: 8]`.
- R5: Trigger fields are 2 bits per interrupt at word 0x700 + 4*(ID/16); bit 2*(ID mod 16)+1 set selects edge and clear selects level, and the even bit of each field reads 0; on an edge interrupt a 0-to-1 change of `irq_i` makes `pend_o` go high one clock later.
- R6: A level interrupt is made pending on every clock edge on which its input is high, so a clear-pending write does not take effect while the input stays high; after the input falls the bit stays set until software clears it.
- R7: IDs below 32 are reached only through the private window (address bit 11 set, word index 0) and shared IDs only through the shared window; a word of the wrong window reads 0 and ignores writes.
- R8: The group register holds one bit per interrupt (1 = group 1), and writing all-ones places every covered interrupt in group 1; the bits appear on `group_o`.
- R9: The control register at shared offset 0x000 has bit 0 = group-0 enable and bit 1 = group-1 enable; `req_o[ID]` is high exactly when the interrupt is pending, enabled and its group is enabled.
- R10: Reads return data on `rdata_o` one cycle after the request; unmapped offsets (including 0x000 in the private window) read 0 and ignore writes.
- R11: After reset every state bit, priority and control bit is 0, and every interrupt of ID 16 or above is level type.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access request for this cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 12 | Byte address; bit 11 selects the private window |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid the cycle after a read request |
| irq_i | input | NUM_IRQ | Interrupt input lines, one per ID |
| en_o | output | NUM_IRQ | Enable vector |
| pend_o | output | NUM_IRQ | Pending vector |
| act_o | output | NUM_IRQ | Active vector |
| group_o | output | NUM_IRQ | Group vector (1 = group 1) |
| prio_o | output | 8*NUM_IRQ | Priority bytes, ID-indexed |
| req_o | output | NUM_IRQ | Pending, enabled and group-enabled interrupts |

## Verification
On every cycle the assertions check the set/clear behaviour of each enable bit, that a rising edge or a held level input makes an interrupt pending on the next edge, and that a software-generated ID never becomes pending unless software asks. They also check that an unmapped read returns zero and that the control bits change only when written. Only the bench scenarios show the address layout: the bit, byte and field positions for every ID, the isolation of the two windows, the read-back of each register, and the gating of `req_o` by the group configuration.

// File: rtl/idg_pkg.sv
package idg_pkg;
  localparam int PRIV_IRQ = 32;
  localparam int SGI_IRQ  = 16;

  typedef enum logic [3:0] {
    K_NONE, K_CTRL, K_GRP, K_ENS, K_ENC, K_PDS, K_PDC, K_ACS, K_ACC, K_PRIO, K_CFG
  } kind_e;
endpackage

// File: rtl/idg_addr_dec.sv
module idg_addr_dec
  import idg_pkg::*;
#(
  parameter int NUM_IRQ = 64
) (
  input  logic [11:0] addr_i,
  output kind_e       kind_o,
  output logic [6:0]  word_o
);
  localparam int NW32 = NUM_IRQ / 32;
  localparam int NW16 = NUM_IRQ / 16;
  localparam int NW8  = NUM_IRQ / 4;

  logic        priv;
  logic [10:0] off;
  logic [4:0]  w5;
  logic [6:0]  w7;
  logic        bit_ok, prio_ok, cfg_ok;
  logic        unused_addr;

  assign priv        = addr_i[11];
  assign off         = addr_i[10:0];
  assign w5          = off[6:2];
  assign w7          = off[8:2];
  assign unused_addr = ^addr_i[1:0];

  // private window owns only the words covering IDs below 32
  assign bit_ok  = priv ? (w5 == 5'd0) : (w5 != 5'd0 && int'(w5) < NW32);
  assign prio_ok = priv ? (int'(w7) < PRIV_IRQ / 4)
                        : (int'(w7) >= PRIV_IRQ / 4 && int'(w7) < NW8);
  assign cfg_ok  = priv ? (int'(w5) < PRIV_IRQ / 16)
                        : (int'(w5) >= PRIV_IRQ / 16 && int'(w5) < NW16);

  always_comb begin
    kind_o = K_NONE;
    word_o = {2'b00, w5};
    case (off[10:7])
      4'h0: if (!priv && w5 == 5'd0) kind_o = K_CTRL;
      4'h1: if (bit_ok) kind_o = K_GRP;
      4'h2: if (bit_ok) kind_o = K_ENS;
      4'h3: if (bit_ok) kind_o = K_ENC;
      4'h4: if (bit_ok) kind_o = K_PDS;
      4'h5: if (bit_ok) kind_o = K_PDC;
      4'h6: if (bit_ok) kind_o = K_ACS;
      4'h7: if (bit_ok) kind_o = K_ACC;
      4'h8, 4'h9, 4'hA, 4'hB: begin
        word_o = w7;
        if (prio_ok) kind_o = K_PRIO;
      end
      4'hE: if (cfg_ok) kind_o = K_CFG;
      default: kind_o = K_NONE;
    endcase
  end
endmodule

// File: rtl/idg_irq_slice.sv
module idg_irq_slice #(
  parameter bit SW_ONLY = 1'b0
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       irq_i,
  input  logic       grp_we_i,
  input  logic       grp_d_i,
  input  logic       en_set_i,
  input  logic       en_clr_i,
  input  logic       pd_set_i,
  input  logic       pd_clr_i,
  input  logic       ac_set_i,
  input  logic       ac_clr_i,
  input  logic       prio_we_i,
  input  logic [7:0] prio_d_i,
  input  logic       cfg_we_i,
  input  logic       cfg_d_i,
  output logic       grp_o,
  output logic       en_o,
  output logic       pend_o,
  output logic       act_o,
  output logic [7:0] prio_o,
  output logic       edge_o
);
  logic irq_q, edge_r, hw_set;

  assign edge_o = SW_ONLY ? 1'b1 : edge_r;
  assign hw_set = !SW_ONLY && (edge_o ? (irq_i && !irq_q) : irq_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q  <= 1'b0;
      edge_r <= 1'b0;
      grp_o  <= 1'b0;
      en_o   <= 1'b0;
      pend_o <= 1'b0;
      act_o  <= 1'b0;
      prio_o <= 8'h00;
    end else begin
      irq_q  <= irq_i;
      if (cfg_we_i)  edge_r <= cfg_d_i;
      if (grp_we_i)  grp_o  <= grp_d_i;
      if (prio_we_i) prio_o <= prio_d_i;
      en_o   <= (en_o & ~en_clr_i) | en_set_i;
      act_o  <= (act_o & ~ac_clr_i) | ac_set_i;
      // hardware set wins over a software clear in the same cycle
      pend_o <= (pend_o & ~pd_clr_i) | pd_set_i | hw_set;
    end
  end

  AST_EN_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_set_i |=> en_o); // R2
  AST_EN_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_clr_i && !en_set_i |=> !en_o); // R2
  AST_EDGE_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !SW_ONLY && edge_o && irq_i && !irq_q |=> pend_o); // R5
  AST_LEVEL_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !SW_ONLY && !edge_o && irq_i |=> pend_o); // R6
  AST_SGI_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    SW_ONLY && !pend_o && !pd_set_i |=> !pend_o); // R1
endmodule

// File: rtl/idg_dist_regs.sv
module idg_dist_regs
  import idg_pkg::*;
#(
  parameter int NUM_IRQ = 64
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_i,
  input  logic                 we_i,
  input  logic [11:0]          addr_i,
  input  logic [31:0]          wdata_i,
  output logic [31:0]          rdata_o,
  input  logic [NUM_IRQ-1:0]   irq_i,
  output logic [NUM_IRQ-1:0]   en_o,
  output logic [NUM_IRQ-1:0]   pend_o,
  output logic [NUM_IRQ-1:0]   act_o,
  output logic [NUM_IRQ-1:0]   group_o,
  output logic [8*NUM_IRQ-1:0] prio_o,
  output logic [NUM_IRQ-1:0]   req_o
);
  kind_e                kind;
  logic [6:0]           word;
  logic                 wr;
  logic [1:0]           ctrl_q;
  logic [NUM_IRQ-1:0]   edge_v;
  logic [2*NUM_IRQ-1:0] cfg_flat;
  logic [31:0]          rd_d;
  logic [11:0]          shamt;

  idg_addr_dec #(.NUM_IRQ(NUM_IRQ)) u_dec (
    .addr_i (addr_i),
    .kind_o (kind),
    .word_o (word)
  );

  assign wr    = req_i && we_i;
  assign shamt = {word, 5'b00000};

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_irq
    localparam int W32 = i / 32;
    localparam int B32 = i % 32;
    localparam int W16 = i / 16;
    localparam int B16 = 2 * (i % 16) + 1;
    localparam int W4  = i / 4;
    localparam int B4  = 8 * (i % 4);
    logic hit32;
    assign hit32 = wr && word == 7'(W32) && wdata_i[B32];

    idg_irq_slice #(.SW_ONLY(i < SGI_IRQ)) u_slice (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .irq_i     (irq_i[i]),
      .grp_we_i  (wr && kind == K_GRP && word == 7'(W32)),
      .grp_d_i   (wdata_i[B32]),
      .en_set_i  (hit32 && kind == K_ENS),
      .en_clr_i  (hit32 && kind == K_ENC),
      .pd_set_i  (hit32 && kind == K_PDS),
      .pd_clr_i  (hit32 && kind == K_PDC),
      .ac_set_i  (hit32 && kind == K_ACS),
      .ac_clr_i  (hit32 && kind == K_ACC),
      .prio_we_i (wr && kind == K_PRIO && word == 7'(W4)),
      .prio_d_i  (wdata_i[B4 +: 8]),
      .cfg_we_i  (wr && kind == K_CFG && word == 7'(W16)),
      .cfg_d_i   (wdata_i[B16]),
      .grp_o     (group_o[i]),
      .en_o      (en_o[i]),
      .pend_o    (pend_o[i]),
      .act_o     (act_o[i]),
      .prio_o    (prio_o[8*i +: 8]),
      .edge_o    (edge_v[i])
    );

    assign cfg_flat[2*i +: 2] = {edge_v[i], 1'b0};
    assign req_o[i] = pend_o[i] && en_o[i] && (group_o[i] ? ctrl_q[1] : ctrl_q[0]);
  end

  always_comb begin
    case (kind)
      K_CTRL:        rd_d = {30'b0, ctrl_q};
      K_GRP:         rd_d = 32'(group_o >> shamt);
      K_ENS, K_ENC:  rd_d = 32'(en_o >> shamt);
      K_PDS, K_PDC:  rd_d = 32'(pend_o >> shamt);
      K_ACS, K_ACC:  rd_d = 32'(act_o >> shamt);
      K_PRIO:        rd_d = 32'(prio_o >> shamt);
      K_CFG:         rd_d = 32'(cfg_flat >> shamt);
      default:       rd_d = 32'h0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= 2'b00;
      rdata_o <= 32'h0;
    end else begin
      if (wr && kind == K_CTRL) ctrl_q <= wdata_i[1:0];
      if (req_i && !we_i)       rdata_o <= rd_d;
    end
  end

  AST_UNMAPPED_RD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !we_i && kind == K_NONE |=> rdata_o == 32'h0); // R10
  AST_CTRL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr && kind == K_CTRL) |=> $stable(ctrl_q)); // R9
  AST_REQ_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|req_o) |-> (|ctrl_q)); // R9
endmodule

// File: tb/tb_idg_dist_regs.sv
`timescale 1ns/1ps
module tb_idg_dist_regs;
  localparam int N = 64;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          req_i = 1'b0, we_i = 1'b0;
  logic [11:0]   addr_i = '0;
  logic [31:0]   wdata_i = '0;
  logic [31:0]   rdata_o;
  logic [N-1:0]  irq_i = '0;
  logic [N-1:0]  en_o, pend_o, act_o, group_o, req_o;
  logic [8*N-1:0] prio_o;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  idg_dist_regs #(.NUM_IRQ(N)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_i(irq_i), .en_o(en_o),
    .pend_o(pend_o), .act_o(act_o), .group_o(group_o), .prio_o(prio_o), .req_o(req_o)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk);
    req_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic bus_rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    req_i = 1'b1; we_i = 1'b0; addr_i = a;
    @(negedge clk);
    req_i = 1'b0;
    d = rdata_o;
  endtask

  function automatic logic [11:0] win(input int id);
    return (id < 32) ? 12'h800 : 12'h000;
  endfunction

  function automatic logic [7:0] prio_of(input int id);
    return 8'((id * 37 + 11) & 255);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [63:0] exp;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R11 reset state
    bus_rd(12'h000, d); chk("R11 ctrl", 64'(d), 64'h0);
    chk("R11 en_o", en_o, 64'h0);
    chk("R11 pend_o", pend_o, 64'h0);
    chk("R11 prio_o", 64'(prio_o), 64'h0);
    bus_rd(12'hF00, d); chk("R1 sgi cfg edge", 64'(d), 64'hAAAA_AAAA);
    bus_rd(12'hF04, d); chk("R11 ppi cfg level", 64'(d), 64'h0);
    bus_rd(12'h708, d); chk("R11 spi cfg level", 64'(d), 64'h0);

    // R3 R2 per-ID enable sweep
    for (int id = 0; id < N; id++) begin
      bus_wr(win(id) + 12'h100 + 12'(4 * (id / 32)), 32'h1 << (id % 32));
      exp = (id == 63) ? '1 : ((64'h1 << (id + 1)) - 64'h1);
      chk("R3 en set sweep", en_o, exp);
    end
    bus_wr(12'h980, 32'hAAAA_AAAA);
    bus_wr(12'h184, 32'hAAAA_AAAA);
    chk("R2 en clear odd", en_o, 64'h5555_5555_5555_5555);
    bus_wr(12'h980, 32'h0);
    chk("R2 zero write no effect", en_o, 64'h5555_5555_5555_5555);
    bus_rd(12'h900, d); chk("R2 read set reg", 64'(d), 64'h5555_5555);
    bus_rd(12'h184, d); chk("R2 read clr reg", 64'(d), 64'h5555_5555);

    // R7 window isolation
    bus_wr(12'h180, 32'hFFFF_FFFF);
    chk("R7 shared word0 write ignored", en_o, 64'h5555_5555_5555_5555);
    bus_rd(12'h100, d); chk("R7 shared word0 reads 0", 64'(d), 64'h0);
    bus_rd(12'h904, d); chk("R7 private word1 reads 0", 64'(d), 64'h0);

    // R4 priority sweep
    for (int w = 0; w < N / 4; w++) begin
      logic [31:0] pw;
      for (int b = 0; b < 4; b++) pw[8*b +: 8] = prio_of(4 * w + b);
      bus_wr(win(4 * w) + 12'h400 + 12'(4 * w), pw);
    end
    for (int id = 0; id < N; id++) begin
      checks++;
      if (prio_o[8*id +: 8] !== prio_of(id)) begin
        errors++;
        $display("FAIL R4 prio_o id %0d actual=%h expected=%h", id, prio_o[8*id +: 8], prio_of(id));
      end
    end
    for (int w = 0; w < N / 4; w++) begin
      logic [31:0] pw;
      for (int b = 0; b < 4; b++) pw[8*b +: 8] = prio_of(4 * w + b);
      bus_rd(win(4 * w) + 12'h400 + 12'(4 * w), d);
      chk("R4 prio readback", 64'(d), 64'(pw));
    end

    // R5 R1 trigger config
    bus_wr(12'hF00, 32'h0);
    bus_rd(12'hF00, d); chk("R1 sgi cfg fixed", 64'(d), 64'hAAAA_AAAA);
    bus_wr(12'hF04, 32'hFFFF_FFFF);
    bus_rd(12'hF04, d); chk("R5 odd bits only", 64'(d), 64'hAAAA_AAAA);
    bus_wr(12'h708, 32'hFFFF_FFFF);
    bus_wr(12'h70C, 32'h0);
    bus_rd(12'h708, d); chk("R5 shared edge word", 64'(d), 64'hAAAA_AAAA);

    // R5 edge id 42
    @(negedge clk); irq_i[42] = 1'b1;
    @(negedge clk); chk("R5 edge sets pending", 64'(pend_o[42]), 64'h1);
    bus_wr(12'h284, 32'h1 << 10);
    chk("R5 edge clear while high", 64'(pend_o[42]), 64'h0);
    // R6 level id 50
    @(negedge clk); irq_i[50] = 1'b1;
    @(negedge clk); chk("R6 level sets pending", 64'(pend_o[50]), 64'h1);
    bus_wr(12'h284, 32'h1 << 18);
    chk("R6 clear blocked while high", 64'(pend_o[50]), 64'h1);
    @(negedge clk); irq_i[50] = 1'b0;
    repeat (2) @(negedge clk);
    chk("R6 latched after fall", 64'(pend_o[50]), 64'h1);
    bus_wr(12'h284, 32'h1 << 18);
    chk("R6 clear after fall", 64'(pend_o[50]), 64'h0);
    // R1 sgi ignores line
    @(negedge clk); irq_i[3] = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 sgi line ignored", 64'(pend_o[3]), 64'h0);
    bus_wr(12'hA00, 32'h10);
    @(negedge clk); irq_i[42] = 1'b0;
    @(negedge clk); irq_i[42] = 1'b1;
    @(negedge clk);
    chk("R2 R5 pending vector", pend_o, (64'h1 << 42) | 64'h10);
    bus_rd(12'h204, d); chk("R2 pend readback", 64'(d), 64'h400);

    // R9 R8 forwarding
    chk("R9 no group enabled", req_o, 64'h0);
    bus_wr(12'h000, 32'h1);
    chk("R9 group0 forwarded", req_o, (64'h1 << 42) | 64'h10);
    bus_wr(12'h880, 32'hFFFF_FFFF);
    bus_wr(12'h084, 32'hFFFF_FFFF);
    chk("R8 group_o all ones", group_o, '1);
    chk("R9 group1 disabled", req_o, 64'h0);
    bus_wr(12'h000, 32'h2);
    chk("R9 group1 forwarded", req_o, (64'h1 << 42) | 64'h10);
    bus_rd(12'h084, d); chk("R8 group readback", 64'(d), 64'hFFFF_FFFF);

    // R2 active
    bus_wr(12'hB00, 32'hF0);
    bus_wr(12'h304, 32'h1);
    chk("R2 active set", act_o, 64'h1_0000_00F0);
    bus_wr(12'hB80, 32'h30);
    chk("R2 active clear", act_o, 64'h1_0000_00C0);
    bus_wr(12'h384, 32'h0);
    chk("R2 active zero write", act_o, 64'h1_0000_00C0);

    // R10 unmapped
    bus_rd(12'h000, d); chk("R10 ctrl read", 64'(d), 64'h2);
    bus_rd(12'h7F0, d); chk("R10 unmapped reads 0", 64'(d), 64'h0);
    bus_wr(12'h800, 32'h3);
    bus_rd(12'h800, d); chk("R10 private ctrl reads 0", 64'(d), 64'h0);
    bus_rd(12'h000, d); chk("R10 private ctrl write ignored", 64'(d), 64'h2);
    bus_wr(12'h7F0, 32'hFFFF_FFFF);
    chk("R10 unmapped write ignored", en_o, 64'h5555_5555_5555_5555);
    bus_rd(12'h908, d); chk("R7 private word2 reads 0", 64'(d), 64'h0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule